// File: doc/BRIEF.md
# Shadowed Calendar Clock with Alarm Compare

This block is a calendar clock advanced by a one-pulse-per-second tick input. It holds seven live fields (seconds, minutes, hours, day of month, weekday, month, year offset) and a second set of seven live alarm fields. Software reaches it through a plain 16-bit register port. Time, alarm, alarm-mask and interrupt-enable writes never touch the running state directly. They land in shadow registers and take effect together when software writes the commit register. A busy bit stays high while that commit is in flight, so one update can never be half applied when a tick or an alarm match lands in the middle of it.

After each tick the alarm unit compares the live time with the live alarm fields. Any field can be left out of the compare through a per-field mask. A match raises a level interrupt and latches a pending flag. In one-shot mode the match also disarms the alarm. The register port never stalls: a write is taken on every clock edge where `reg_wr` is high, and `reg_rdata` shows the addressed register in the same cycle, so no valid/ready handshake or back-pressure exists at this edge. Reads return live values only.

Top module: `rtc_shadow_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 1, weekday 1, month 1, year offset 0. Busy, alarm_irq, alarm enable and the pending flag all read 0.
- R2: Register addresses are as follows. Time fields sit at 0x08+i and alarm fields at 0x10+i, where i=0..6 selects seconds, minutes, hours, day, weekday, month, year. Interrupt enable is at 0x02 and the alarm mask is at 0x03. A write to any of these reaches only its shadow copy. A read returns the live value, which does not change until a commit.
- R3: Writing a word with bit 0 set to address 0x05 while idle sets busy (bit 6 of address 0x00) for exactly COMMIT_CYC cycles, then copies the shadows into the live registers. A trigger written while busy is ignored and does not lengthen the busy window.
- R4: A commit copies only the groups written since the previous commit. The groups are: time; alarm fields together with the mask; interrupt enable.
- R5: Each tick advances seconds. Seconds 59 wrap to 0 and carry into minutes. Minutes 59 wrap to 0 and carry into hours. Hours 23 wrap to 0 and carry into the day.
- R6: Day of month wraps to 1 after the month's last day. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year offset is divisible by 4 and 28 otherwise. All other months have 31 days. On each day change the weekday goes from 7 to 1. Month 12 wraps to 1 and increments the year. Year offset 127 wraps to 0.
- R7: With enable set (bit 0 of 0x02), a tick that leaves every unmasked live time field equal to the live alarm field sets status bit 0 of 0x01 and alarm_irq on the second clock edge after the tick is sampled. The level holds until a 1 is written to bit 0 of 0x01.
- R8: Bit i of the alarm mask removes field i from the compare. Bit 4 removes the weekday.
- R9: With one-shot set (bit 2 of 0x02), a match clears enable bit 0 and leaves one-shot set, so no later match fires. Without one-shot, enable stays set and a later match fires again.
- R10: A match also sets bit 4 of 0x04. Clearing the status bit leaves it set. Writing 1 to bit 4 of 0x04 clears it.
- R11: With enable clear, a matching tick leaves the status bit, the pending flag and alarm_irq at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, same cycle |
| alarm_irq | output | 1 | Active-high level alarm interrupt |

## Verification
The hardest case to reach is a tick that carries through every field at once, such as the last second of a leap-year February or of year offset 127. Reaching it by ticking alone would take years of simulated seconds. The bench instead loads the second before each boundary through the shadow-and-commit path and then issues a single tick. The alarm cases use the same method: the live time is committed one second short of the alarm, and the enable group is re-committed between runs so that one-shot disarming and repeated firing can both be observed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 7;
  localparam int FW     = 7;
  localparam int AW     = 6;
  localparam int DW     = 16;

  typedef logic [NFIELD-1:0][FW-1:0] cal_t;

  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DOM = 3, F_DOW = 4, F_MON = 5, F_YEAR = 6;

  localparam logic [AW-1:0] A_CTRL  = 6'h00;
  localparam logic [AW-1:0] A_ISTAT = 6'h01;
  localparam logic [AW-1:0] A_IEN   = 6'h02;
  localparam logic [AW-1:0] A_AMASK = 6'h03;
  localparam logic [AW-1:0] A_PEND  = 6'h04;
  localparam logic [AW-1:0] A_TRIG  = 6'h05;
  localparam logic [AW-1:0] A_TIME  = 6'h08;
  localparam logic [AW-1:0] A_ALRM  = 6'h10;

  localparam int B_BUSY = 6, B_EN = 0, B_OS = 2, B_STA = 0, B_PEND = 4;

  function automatic logic [FW-1:0] field_mask(input int idx);
    case (idx)
      F_SEC, F_MIN:  return 7'h3F;
      F_HOUR, F_DOM: return 7'h1F;
      F_DOW:         return 7'h07;
      F_MON:         return 7'h0F;
      default:       return 7'h7F;
    endcase
  endfunction

  function automatic cal_t cal_reset();
    cal_t c;
    c        = '0;
    c[F_DOM] = 7'd1;
    c[F_DOW] = 7'd1;
    c[F_MON] = 7'd1;
    return c;
  endfunction

  function automatic logic [FW-1:0] month_len(input logic [FW-1:0] mon, input logic [FW-1:0] yr);
    case (mon)
      7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  cal_t load_val,
  output cal_t now
);
  cal_t nxt;
  logic last_sec, last_min, last_hour, last_dom;

  always_comb begin
    last_sec  = now[F_SEC]  >= 7'd59;
    last_min  = now[F_MIN]  >= 7'd59;
    last_hour = now[F_HOUR] >= 7'd23;
    last_dom  = now[F_DOM]  >= month_len(now[F_MON], now[F_YEAR]);
    nxt = now;
    if (!last_sec) nxt[F_SEC] = now[F_SEC] + 7'd1;
    else begin
      nxt[F_SEC] = '0;
      if (!last_min) nxt[F_MIN] = now[F_MIN] + 7'd1;
      else begin
        nxt[F_MIN] = '0;
        if (!last_hour) nxt[F_HOUR] = now[F_HOUR] + 7'd1;
        else begin
          nxt[F_HOUR] = '0;
          nxt[F_DOW]  = (now[F_DOW] >= 7'd7) ? 7'd1 : now[F_DOW] + 7'd1;
          if (!last_dom) nxt[F_DOM] = now[F_DOM] + 7'd1;
          else begin
            nxt[F_DOM] = 7'd1;
            if (now[F_MON] >= 7'd12) begin
              nxt[F_MON]  = 7'd1;
              nxt[F_YEAR] = now[F_YEAR] + 7'd1;
            end else begin
              nxt[F_MON] = now[F_MON] + 7'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    now <= cal_reset();
    else if (load) now <= load_val;
    else if (tick) now <= nxt;
  end

  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && now[F_SEC] == 7'd59 |=> now[F_SEC] == 7'd0);
  p_dom_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && now[F_SEC] == 7'd59 && now[F_MIN] == 7'd59 && now[F_HOUR] == 7'd23
    && now[F_DOM] == month_len(now[F_MON], now[F_YEAR]) |=> now[F_DOM] == 7'd1);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load |=> $stable(now));
endmodule

// File: rtl/rtc_commit_timer.sv
module rtc_commit_timer #(
  parameter int COMMIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (COMMIT_CYC > 1) ? $clog2(COMMIT_CYC) : 1;
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(COMMIT_CYC - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  cal_t              now,
  input  cal_t              alarm,
  input  logic [NFIELD-1:0] mask,
  input  logic              en,
  output logic              hit
);
  logic              eval_q;
  logic [NFIELD-1:0] fld_ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign fld_ok[i] = mask[i] || (now[i] == alarm[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) eval_q <= 1'b0;
    else        eval_q <= tick;
  end

  assign hit = eval_q && en && (&fld_ok);

  p_hit_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(tick));
endmodule

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core
  import rtc_pkg::*;
#(
  parameter int COMMIT_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          alarm_irq
);
  cal_t              sh_time, sh_alrm, lv_alrm, now;
  logic [NFIELD-1:0] sh_mask, lv_mask;
  logic              sh_en, sh_os, lv_en, lv_os;
  logic              d_time, d_alrm, d_ien;
  logic              irq_sta, pend;
  logic              busy, done, hit, start;
  logic              wr_time, wr_alrm, wr_ien, wr_mask;

  always_comb begin
    wr_time = 1'b0;
    wr_alrm = 1'b0;
    for (int i = 0; i < NFIELD; i++) begin
      if (reg_wr && reg_addr == A_TIME + AW'(i)) wr_time = 1'b1;
      if (reg_wr && reg_addr == A_ALRM + AW'(i)) wr_alrm = 1'b1;
    end
  end
  assign wr_ien  = reg_wr && reg_addr == A_IEN;
  assign wr_mask = reg_wr && reg_addr == A_AMASK;
  assign start   = reg_wr && reg_addr == A_TRIG && reg_wdata[0];

  rtc_commit_timer #(.COMMIT_CYC(COMMIT_CYC)) u_commit (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
    .load(done && d_time), .load_val(sh_time), .now(now)
  );

  rtc_alarm_cmp u_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .now(now),
    .alarm(lv_alrm), .mask(lv_mask), .en(lv_en), .hit(hit)
  );

  // shadow registers and dirty flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_time <= cal_reset();
      sh_alrm <= cal_reset();
      sh_mask <= '0;
      sh_en   <= 1'b0;
      sh_os   <= 1'b0;
      d_time  <= 1'b0;
      d_alrm  <= 1'b0;
      d_ien   <= 1'b0;
    end else begin
      for (int i = 0; i < NFIELD; i++) begin
        if (reg_wr && reg_addr == A_TIME + AW'(i)) sh_time[i] <= reg_wdata[FW-1:0] & field_mask(i);
        if (reg_wr && reg_addr == A_ALRM + AW'(i)) sh_alrm[i] <= reg_wdata[FW-1:0] & field_mask(i);
      end
      if (wr_mask) sh_mask <= reg_wdata[NFIELD-1:0];
      if (wr_ien) begin
        sh_en <= reg_wdata[B_EN];
        sh_os <= reg_wdata[B_OS];
      end
      d_time <= (d_time && !done) || wr_time;
      d_alrm <= (d_alrm && !done) || wr_alrm || wr_mask;
      d_ien  <= (d_ien  && !done) || wr_ien;
    end
  end

  // live alarm state, status and pending
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lv_alrm <= cal_reset();
      lv_mask <= '0;
      lv_en   <= 1'b0;
      lv_os   <= 1'b0;
      irq_sta <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (done && d_alrm) begin
        lv_alrm <= sh_alrm;
        lv_mask <= sh_mask;
      end
      if (done && d_ien) begin
        lv_en <= sh_en;
        lv_os <= sh_os;
      end else if (hit && lv_os) begin
        lv_en <= 1'b0;
      end
      if (hit) irq_sta <= 1'b1;
      else if (reg_wr && reg_addr == A_ISTAT && reg_wdata[B_STA]) irq_sta <= 1'b0;
      if (hit) pend <= 1'b1;
      else if (reg_wr && reg_addr == A_PEND && reg_wdata[B_PEND]) pend <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[B_BUSY] = busy;
      A_ISTAT: reg_rdata[B_STA]  = irq_sta;
      A_IEN:   begin reg_rdata[B_EN] = lv_en; reg_rdata[B_OS] = lv_os; end
      A_AMASK: reg_rdata[NFIELD-1:0] = lv_mask;
      A_PEND:  reg_rdata[B_PEND] = pend;
      default: ;
    endcase
    for (int i = 0; i < NFIELD; i++) begin
      if (reg_addr == A_TIME + AW'(i)) reg_rdata[FW-1:0] = now[i];
      if (reg_addr == A_ALRM + AW'(i)) reg_rdata[FW-1:0] = lv_alrm[i];
    end
  end

  assign alarm_irq = irq_sta;

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq && !(reg_wr && reg_addr == A_ISTAT && reg_wdata[B_STA]) |=> alarm_irq);
  p_oneshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit && lv_os && !(done && d_ien) |=> !lv_en);
  p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);
  p_en_shadowed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien && !done && !hit |=> $stable(lv_en));
  p_sta_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sta) |-> $past(hit));
endmodule

// File: tb/test_rtc_shadow_core.sv
module test_rtc_shadow_core;
  localparam int CYC = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        alarm_irq;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rtc_shadow_core #(.COMMIT_CYC(CYC)) i_rtc_shadow_core (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic commit();
    wr(6'h05, 16'h1);
    repeat (CYC + 1) @(negedge clk);
  endtask

  task automatic tick1();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input int s, mi, h, dm, dw, mo, y);
    wr(6'h08, 16'(s)); wr(6'h09, 16'(mi)); wr(6'h0A, 16'(h));
    wr(6'h0B, 16'(dm)); wr(6'h0C, 16'(dw)); wr(6'h0D, 16'(mo)); wr(6'h0E, 16'(y));
    commit();
  endtask

  task automatic set_alarm(input int s, mi, h, dm, dw, mo, y, msk, ien);
    wr(6'h10, 16'(s)); wr(6'h11, 16'(mi)); wr(6'h12, 16'(h));
    wr(6'h13, 16'(dm)); wr(6'h14, 16'(dw)); wr(6'h15, 16'(mo)); wr(6'h16, 16'(y));
    wr(6'h03, 16'(msk)); wr(6'h02, 16'(ien));
    commit();
  endtask

  task automatic chk_time(input string req, input int s, mi, h, dm, dw, mo, y);
    int v;
    int exp [7];
    exp = '{s, mi, h, dm, dw, mo, y};
    for (int i = 0; i < 7; i++) begin
      rd(6'(8 + i), v);
      check(req, v, exp[i]);
    end
  endtask

  task automatic t_reset();
    int v;
    chk_time("R1 time", 0, 0, 0, 1, 1, 1, 0);
    rd(6'h00, v); check("R1 busy", v, 0);
    rd(6'h02, v); check("R1 enable", v, 0);
    rd(6'h04, v); check("R1 pending", v, 0);
    check("R1 irq", int'(alarm_irq), 0);
  endtask

  task automatic t_shadow();
    int v;
    wr(6'h08, 16'd45);
    rd(6'h08, v); check("R2 sec before commit", v, 0);
    wr(6'h02, 16'h1);
    rd(6'h02, v); check("R2 enable before commit", v, 0);
    wr(6'h05, 16'h1);
    rd(6'h00, v); check("R3 busy c1", v, 64);
    @(negedge clk);
    rd(6'h00, v); check("R3 busy c2", v, 64);
    wr(6'h05, 16'h1);
    rd(6'h00, v); check("R3 busy c4", v, 64);
    @(negedge clk);
    rd(6'h00, v); check("R3 busy ends after COMMIT_CYC", v, 0);
    rd(6'h08, v); check("R3 sec committed", v, 45);
    rd(6'h02, v); check("R3 enable committed", v, 1);
    wr(6'h02, 16'h0);
    commit();
  endtask

  task automatic t_partial();
    int v;
    set_time(10, 0, 0, 1, 1, 1, 0);
    tick1(); tick1();
    wr(6'h10, 16'd5);
    commit();
    rd(6'h08, v); check("R4 time group untouched", v, 12);
    rd(6'h10, v); check("R4 alarm group copied", v, 5);
  endtask

  task automatic t_hms();
    set_time(30, 9, 4, 5, 3, 6, 10);
    tick1(); chk_time("R5 plain second", 31, 9, 4, 5, 3, 6, 10);
    set_time(59, 9, 4, 5, 3, 6, 10);
    tick1(); chk_time("R5 minute carry", 0, 10, 4, 5, 3, 6, 10);
    set_time(59, 59, 23, 5, 3, 6, 10);
    tick1(); chk_time("R5 day carry", 0, 0, 0, 6, 4, 6, 10);
  endtask

  task automatic t_cal();
    set_time(59, 59, 23, 28, 2, 2, 0);
    tick1(); chk_time("R6 leap feb 29", 0, 0, 0, 29, 3, 2, 0);
    set_time(59, 59, 23, 28, 2, 2, 1);
    tick1(); chk_time("R6 plain feb end", 0, 0, 0, 1, 3, 3, 1);
    set_time(59, 59, 23, 29, 7, 2, 4);
    tick1(); chk_time("R6 leap feb end weekday wrap", 0, 0, 0, 1, 1, 3, 4);
    set_time(59, 59, 23, 30, 2, 4, 9);
    tick1(); chk_time("R6 thirty-day month", 0, 0, 0, 1, 3, 5, 9);
    set_time(59, 59, 23, 31, 5, 12, 127);
    tick1(); chk_time("R6 year wrap", 0, 0, 0, 1, 6, 1, 0);
  endtask

  task automatic t_alarm();
    int v;
    set_alarm(31, 20, 10, 5, 3, 6, 10, 0, 1);
    set_time(30, 20, 10, 5, 3, 6, 10);
    check("R7 idle before tick", int'(alarm_irq), 0);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    check("R7 not yet one edge after tick", int'(alarm_irq), 0);
    @(negedge clk);
    check("R7 irq on second edge", int'(alarm_irq), 1);
    rd(6'h01, v); check("R7 status bit", v, 1);
    repeat (5) @(negedge clk);
    check("R7 level held", int'(alarm_irq), 1);
    wr(6'h01, 16'h1);
    check("R7 cleared by write", int'(alarm_irq), 0);
    rd(6'h04, v); check("R10 pending survives status clear", v, 16);
    wr(6'h04, 16'h10);
    rd(6'h04, v); check("R10 pending cleared", v, 0);
  endtask

  task automatic t_mask();
    set_alarm(31, 20, 10, 5, 5, 6, 10, 16, 1);
    set_time(30, 20, 10, 5, 3, 6, 10);
    tick1(); check("R8 weekday masked fires", int'(alarm_irq), 1);
    wr(6'h01, 16'h1);
    set_alarm(31, 20, 10, 5, 5, 6, 10, 0, 1);
    set_time(30, 20, 10, 5, 3, 6, 10);
    tick1(); check("R8 weekday compared no fire", int'(alarm_irq), 0);
    set_alarm(50, 20, 10, 5, 3, 6, 10, 1, 1);
    set_time(30, 20, 10, 5, 3, 6, 10);
    tick1(); check("R8 seconds masked fires", int'(alarm_irq), 1);
    wr(6'h01, 16'h1);
    wr(6'h04, 16'h10);
  endtask

  task automatic t_oneshot();
    int v;
    set_alarm(31, 20, 10, 5, 3, 6, 10, 0, 5);
    set_time(30, 20, 10, 5, 3, 6, 10);
    tick1(); check("R9 one-shot fires", int'(alarm_irq), 1);
    rd(6'h02, v); check("R9 enable cleared, one-shot kept", v, 4);
    wr(6'h01, 16'h1);
    set_time(30, 20, 10, 5, 3, 6, 10);
    tick1(); check("R9 no refire", int'(alarm_irq), 0);
    set_alarm(31, 20, 10, 5, 3, 6, 10, 0, 1);
    set_time(30, 20, 10, 5, 3, 6, 10);
    tick1(); check("R9 repeat first", int'(alarm_irq), 1);
    rd(6'h02, v); check("R9 enable kept", v, 1);
    wr(6'h01, 16'h1);
    set_time(30, 20, 10, 5, 3, 6, 10);
    tick1(); check("R9 repeat second", int'(alarm_irq), 1);
    wr(6'h01, 16'h1);
    wr(6'h04, 16'h10);
  endtask

  task automatic t_disabled();
    int v;
    set_alarm(31, 20, 10, 5, 3, 6, 10, 0, 0);
    set_time(30, 20, 10, 5, 3, 6, 10);
    tick1();
    check("R11 irq stays low", int'(alarm_irq), 0);
    rd(6'h01, v); check("R11 status stays low", v, 0);
    rd(6'h04, v); check("R11 pending stays low", v, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_partial();
    t_hms();
    t_cal();
    t_alarm();
    t_mask();
    t_oneshot();
    t_disabled();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule